// File: doc/BRIEF.md
# DC Bus Voltage Regulator with Three-Phase Current Reference Generation

This block closes the outer voltage loop of a three-phase four-wire inverter whose neutral sits at the midpoint of a split DC capacitor bank. On every sample strobe it adds the two sensed half-bus voltages, subtracts the sum from a bus voltage setpoint and runs a proportional-integral regulator. The regulator output is the active-axis (q) current command. A fixed reactive-axis (d) command comes in as a configuration input, and the block projects the d/q pair onto the three phases using grid-synchronised sine and cosine unit vectors supplied from outside.

The three phase current references and the q command are registered together and announced by a single-cycle valid pulse two clocks after the strobe. They feed per-phase resonant current controllers. All data are signed 16-bit per-unit values, and the integrator is 32 bits wide. The proportional and integral gains are fixed-point parameters with `FB` fractional bits. With the default gains the integral time constant matches the bus RC time constant, so the regulator zero cancels the plant pole.

Top module: `dcbus_pi_refgen`

## Requirements
- R1: The total bus voltage is the signed sum of `vhi_i` and `vlo_i`, saturated to the 16-bit signed range.
- R2: The regulator error is `vref_i` minus the total bus voltage, saturated to the 16-bit signed range.
- R3: The q command is floor((KP·err + acc) / 2^FB), clamped to ±`iq_lim_i`. Here acc is the integrator value held before this sample.
- R4: On each sample the integrator adds KI·err and is then clamped to ±(`iq_lim_i`·2^FB). It is zero after reset.
- R5: The integrator holds its value when the unclamped q command exceeds +`iq_lim_i` with a positive error, or falls below −`iq_lim_i` with a negative error.
- R6: Phase a reference = floor((iq·s + id·c) / 2^14), saturated to 16 bits. Here s and c are `sin_i` and `cos_i` in Q2.14, and id is `id_ref_i`.
- R7: Phase b uses the unit vectors rotated by −120°: sb = floor((−8192·s − 14189·c) / 2^14) and cb = floor((−8192·c + 14189·s) / 2^14). Its reference is floor((iq·sb + id·cb) / 2^14), saturated.
- R8: Phase c = floor(−(iq·s + id·c + iq·sb + id·cb) / 2^14), saturated. Unless an output saturates, the three phase references therefore sum to a value between −2 and 0.
- R9: `sample_i` high in cycle k gives `valid_o` high for exactly cycle k+2, with all four outputs updated in that cycle. Outputs never change in a cycle without `valid_o`.
- R10: After reset all outputs and `valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sample strobe, one cycle per control period |
| vhi_i | input | 16 | Upper half-bus voltage, signed per unit |
| vlo_i | input | 16 | Lower half-bus voltage, signed per unit |
| vref_i | input | 16 | Total bus voltage setpoint |
| id_ref_i | input | 16 | Constant reactive-axis current command |
| iq_lim_i | input | 16 | Active current limit, non-negative |
| sin_i | input | 16 | Grid angle sine, Q2.14 |
| cos_i | input | 16 | Grid angle cosine, Q2.14 |
| iq_o | output | 16 | Active-axis current command |
| ia_o | output | 16 | Phase a current reference |
| ib_o | output | 16 | Phase b current reference |
| ic_o | output | 16 | Phase c current reference |
| valid_o | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
A wrong integrator value is not visible at the ports right away. It shows as an offset in `iq_o` on the following strobe, so each strobe's q command is compared with a model that carries its own integrator across hundreds of samples. A corrupted rotation constant or phase projection shows on the same valid pulse as a wrong phase b or c value, and as a three-phase sum outside the rounding band. A windup fault shows only after the error reverses sign, so the limit tests drive the regulator into saturation and then back out.

// File: rtl/dcbus_pi_refgen.sv
module dcbus_pi_refgen #(
  parameter int DW  = 16,
  parameter int IW  = 32,
  parameter int FB  = 16,
  parameter int KP  = 406323,
  parameter int KI  = 1,
  parameter int UF  = 14,
  parameter int SQ3 = 14189
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic signed [DW-1:0] vhi_i,
  input  logic signed [DW-1:0] vlo_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] id_ref_i,
  input  logic signed [DW-1:0] iq_lim_i,
  input  logic signed [DW-1:0] sin_i,
  input  logic signed [DW-1:0] cos_i,
  output logic signed [DW-1:0] iq_o,
  output logic signed [DW-1:0] ia_o,
  output logic signed [DW-1:0] ib_o,
  output logic signed [DW-1:0] ic_o,
  output logic                 valid_o
);

  localparam longint MAXL = (longint'(1) <<< (DW-1)) - 1;
  localparam longint MINL = -MAXL - 1;
  localparam longint HALF = longint'(1) <<< (UF-1);

  function automatic logic signed [DW-1:0] sat(input longint x);
    longint y;
    y = (x > MAXL) ? MAXL : (x < MINL) ? MINL : x;
    return y[DW-1:0];
  endfunction

  logic signed [IW-1:0] acc;
  logic signed [DW-1:0] iq_s, id_s, sin_s, cos_s;
  logic                 v1;

  longint tot, err, lim, alim, uraw, u, anext, sb, cb, pa, pb;
  logic   hi, lo, hold;

  always_comb begin
    tot   = longint'(sat(longint'(vhi_i) + longint'(vlo_i)));
    err   = longint'(sat(longint'(vref_i) - tot));
    lim   = (iq_lim_i < 0) ? 0 : longint'(iq_lim_i);
    alim  = lim <<< FB;
    uraw  = (longint'(KP) * err + longint'(acc)) >>> FB;
    hi    = uraw > lim;
    lo    = uraw < -lim;
    u     = hi ? lim : lo ? -lim : uraw;
    hold  = (hi && err > 0) || (lo && err < 0);
    anext = hold ? longint'(acc) : longint'(acc) + longint'(KI) * err;
    if (anext > alim)  anext = alim;
    if (anext < -alim) anext = -alim;
  end

  always_comb begin
    sb = (-HALF * longint'(sin_s) - longint'(SQ3) * longint'(cos_s)) >>> UF;
    cb = (-HALF * longint'(cos_s) + longint'(SQ3) * longint'(sin_s)) >>> UF;
    pa = longint'(iq_s) * longint'(sin_s) + longint'(id_s) * longint'(cos_s);
    pb = longint'(iq_s) * sb + longint'(id_s) * cb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      iq_s  <= '0;
      id_s  <= '0;
      sin_s <= '0;
      cos_s <= '0;
      v1    <= 1'b0;
    end else begin
      v1 <= sample_i;
      if (sample_i) begin
        acc   <= anext[IW-1:0];
        iq_s  <= sat(u);
        id_s  <= id_ref_i;
        sin_s <= sin_i;
        cos_s <= cos_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_o    <= '0;
      ia_o    <= '0;
      ib_o    <= '0;
      ic_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= v1;
      if (v1) begin
        iq_o <= iq_s;
        ia_o <= sat(pa >>> UF);
        ib_o <= sat(pb >>> UF);
        ic_o <= sat((-pa - pb) >>> UF);
      end
    end
  end

endmodule

// File: rtl/dcbus_pi_refgen_chk.sv
module dcbus_pi_refgen_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_i,
  input logic signed [DW-1:0] iq_lim_i,
  input logic signed [DW-1:0] iq_o,
  input logic signed [DW-1:0] ia_o,
  input logic signed [DW-1:0] ib_o,
  input logic signed [DW-1:0] ic_o,
  input logic                 valid_o
);

  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW+1:0] sum3;
  logic                 any_sat;
  assign sum3 = (DW+2)'(ia_o) + (DW+2)'(ib_o) + (DW+2)'(ic_o);
  assign any_sat = ia_o == MAXV || ia_o == MINV || ib_o == MAXV ||
                   ib_o == MINV || ic_o == MAXV || ic_o == MINV;

  assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> ##1 valid_o);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> ##1 !valid_o);

  assert_outputs_change_on_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ia_o) || !$stable(ib_o) || !$stable(ic_o) || !$stable(iq_o)) |-> valid_o);

  assert_iq_within_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && iq_lim_i >= 0) |=> ##1
      (iq_o <= $past(iq_lim_i, 2) && iq_o >= -$past(iq_lim_i, 2)));

  assert_phase_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (any_sat || (sum3 <= 0 && sum3 >= -2)));

  assert_reset_state_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!valid_o && iq_o == 0 && ia_o == 0 && ib_o == 0 && ic_o == 0));

endmodule

bind dcbus_pi_refgen dcbus_pi_refgen_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_dcbus_pi_refgen.sv
module test_dcbus_pi_refgen;
  localparam int DW = 16, FB = 16, KP = 65536, KI = 16384;

  logic clk = 1'b0, rst_n = 1'b0, sample_i = 1'b0;
  logic signed [DW-1:0] vhi_i = '0, vlo_i = '0, vref_i = '0, id_ref_i = '0;
  logic signed [DW-1:0] iq_lim_i = 16'sd20000, sin_i = '0, cos_i = '0;
  logic signed [DW-1:0] iq_o, ia_o, ib_o, ic_o;
  logic valid_o;

  int checks = 0, errors = 0;
  longint m_acc = 0;
  bit done = 0;

  always #2.5ns clk = ~clk;

  dcbus_pi_refgen #(.DW(DW), .FB(FB), .KP(KP), .KI(KI)) i_dcbus_pi_refgen (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .vhi_i(vhi_i), .vlo_i(vlo_i),
    .vref_i(vref_i), .id_ref_i(id_ref_i), .iq_lim_i(iq_lim_i), .sin_i(sin_i),
    .cos_i(cos_i), .iq_o(iq_o), .ia_o(ia_o), .ib_o(ib_o), .ic_o(ic_o),
    .valid_o(valid_o));

  function automatic longint clip(input longint x);
    return (x > 32767) ? 32767 : (x < -32768) ? -32768 : x;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input longint hi, input longint lo, input longint ref_v,
                      input longint id, input longint lim, input longint s,
                      input longint c, input string tag);
    longint tot, err, uraw, u, an, alim, sb, cb, pa, pb;
    bit h, l;
    tot  = clip(hi + lo);
    err  = clip(ref_v - tot);
    uraw = (KP * err + m_acc) >>> FB;
    h = uraw > lim; l = uraw < -lim;
    u = h ? lim : l ? -lim : uraw;
    an = ((h && err > 0) || (l && err < 0)) ? m_acc : m_acc + KI * err;
    alim = lim <<< FB;
    if (an > alim) an = alim;
    if (an < -alim) an = -alim;
    m_acc = an;
    sb = (-8192 * s - 14189 * c) >>> 14;
    cb = (-8192 * c + 14189 * s) >>> 14;
    pa = u * s + id * c;
    pb = u * sb + id * cb;
    @(negedge clk);
    vhi_i = 16'(hi); vlo_i = 16'(lo); vref_i = 16'(ref_v); id_ref_i = 16'(id);
    iq_lim_i = 16'(lim); sin_i = 16'(s); cos_i = 16'(c); sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    chk("R9 valid early", longint'(valid_o), 0);
    @(negedge clk);
    chk("R9 valid", longint'(valid_o), 1);
    chk({tag, " iq"}, longint'(iq_o), u);
    chk("R6 ia", longint'(ia_o), clip(pa >>> 14));
    chk("R7 ib", longint'(ib_o), clip(pb >>> 14));
    chk("R8 ic", longint'(ic_o), clip((-pa - pb) >>> 14));
    @(negedge clk);
    chk("R9 single pulse", longint'(valid_o), 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint qa, qb, qc, qq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid", longint'(valid_o), 0);
    chk("R10 iq", longint'(iq_o), 0);
    chk("R10 ia", longint'(ia_o), 0);
    chk("R10 ib", longint'(ib_o), 0);
    chk("R10 ic", longint'(ic_o), 0);

    // R1 sum saturation, R2 error saturation
    step(30000, 30000, 0, 0, 32767, 16384, 0, "R1");
    step(-30000, -30000, 30000, 0, 32767, 0, 16384, "R2");
    step(-20000, 5000, 100, 500, 32767, 11585, 11585, "R3");

    // R9: outputs hold without strobe
    qq = iq_o; qa = ia_o; qb = ib_o; qc = ic_o;
    repeat (6) @(negedge clk);
    chk("R9 hold valid", longint'(valid_o), 0);
    chk("R9 hold iq", longint'(iq_o), qq);
    chk("R9 hold ia", longint'(ia_o), qa);
    chk("R9 hold ib", longint'(ib_o), qb);
    chk("R9 hold ic", longint'(ic_o), qc);

    // R4/R5: drive into saturation, then reverse the error
    for (int k = 0; k < 20; k++) step(0, 0, 3000, 0, 100, 16384, 0, "R5");
    for (int k = 0; k < 20; k++) step(0, 0, -40, 0, 100, 16384, 0, "R5");
    for (int k = 0; k < 20; k++) step(0, 0, 60, 0, 25000, 0, 16384, "R4");

    // sweep over angles and operating points
    for (int k = 0; k < 600; k++) begin
      real th;
      longint s, c;
      th = 6.283185307179586 * real'(k) / 37.0;
      s = longint'($floor(16384.0 * $sin(th) + 0.5));
      c = longint'($floor(16384.0 * $cos(th) + 0.5));
      step(((k * 731) % 8000) - 4000, ((k * 377) % 8000) - 4000,
           ((k * 193) % 6000) - 3000, ((k * 97) % 4000) - 2000,
           20000 - (k % 5) * 3000, s, c, "R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule